// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block sits between a host interconnect and the transaction layer of a PCIe root port. Software programs a small set of outbound windows through a 32-bit register port. It first picks a window with an index register and then reaches that window's registers at fixed offsets. Each window maps a host address range onto a 64-bit bus address and attaches a transaction type: memory, I/O, configuration type 0 or configuration type 1.

Every host address presented to the block is checked against all active windows in the same cycle. The block returns the translated bus address and the type of the lowest-numbered matching window. When no window matches, it raises a no-match flag and passes the address through unchanged. The index register recognises more indices than there are windows. Software discovers how many indices exist from the value of the index register when all ones is written to it. It discovers how many windows those indices hold by finding where a probe value stops sticking in the lower target register.

Top module: `atu_window_unit`

## Requirements
- R1: After reset the index register reads 0, every window register reads 0, and every lookup misses.
- R2: The index register sits at byte offset 0x00, with the index in bits [7:0]. Writing an index above NUM_VIEWS-1 (all ones included) stores NUM_VIEWS-1. Reading returns the stored index (5 with the defaults).
- R3: For the selected window, the registers read back as written. Type is at 0x04 in bits [4:0], with codes memory=0, I/O=2, config type 0=4, config type 1=5. Enable is at 0x08 in bit 31. Base low is at 0x0C, base high at 0x10, limit at 0x14, target low at 0x18 and target high at 0x1C.
- R4: Indices NUM_OUT to NUM_VIEWS-1 have no window. Their registers read 0 and ignore writes, so writing 0x12340000 to target low reads back 0. With the defaults, the first index where the probe fails to stick is 4.
- R5: After enable is written to 1 on an inactive window, the enable bit reads 0 for SETTLE_CYCLES clock edges (3 by default) and 1 from then on. The window takes part in lookups only once the bit reads 1. Writing enable to 0 deactivates the window at the next edge.
- R6: A host address hits an active window when its upper 32 bits equal base high and its lower 32 bits lie between base low and limit, both ends included.
- R7: On a hit, the bus address is the 64-bit target plus (host address minus 64-bit base), with carry into the upper word. The output type is the window's type field.
- R8: When several active windows hit, the lowest-numbered one supplies the address and type.
- R9: On a miss, the no-match output is 1, the bus address equals the host address and the type output is 0.
- R10: A lookup made in the same cycle as a register write uses the window contents from before that write. The write takes effect for lookups after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regWordAddr | input | 3 | Register word offset (byte offset / 4) |
| regWData | input | 32 | Register write data |
| regRData | output | 32 | Register read data for regWordAddr, combinational |
| hostAddr | input | 64 | Host address to translate |
| busAddr | output | 64 | Translated (or passed-through) bus address |
| busType | output | 5 | Transaction type of the winning window |
| noMatch | output | 1 | No active window matched hostAddr |

## Verification
Reprogramming a window and looking up an address through that same window can fall in one clock cycle. The bench provokes this by presenting a host address inside an active window while, in the same cycle, writing a new target low value or clearing the enable bit of that window. Before the edge, the output must still carry the old translation. After the edge, it must carry the new target, or fall through to the next-lowest window once the enable is cleared.

// File: rtl/atu_pkg.sv
package atu_pkg;

  localparam int REG_IDX_W = 8;

  // Word offsets of the per-window registers, index register at word 0
  typedef enum logic [2:0] {
    FLD_VIEW    = 3'd0,
    FLD_CTRL1   = 3'd1,
    FLD_CTRL2   = 3'd2,
    FLD_BASE_LO = 3'd3,
    FLD_BASE_HI = 3'd4,
    FLD_LIMIT   = 3'd5,
    FLD_TGT_LO  = 3'd6,
    FLD_TGT_HI  = 3'd7
  } fieldSel_e;

  localparam logic [4:0] TYPE_MEM  = 5'd0;
  localparam logic [4:0] TYPE_IO   = 5'd2;
  localparam logic [4:0] TYPE_CFG0 = 5'd4;
  localparam logic [4:0] TYPE_CFG1 = 5'd5;

  localparam int ENABLE_BIT = 31;

  // Strobes from register control to the window datapath
  typedef struct packed {
    logic                 wrEn;
    fieldSel_e            field;
    logic [REG_IDX_W-1:0] region;
    logic [31:0]          data;
  } regStrobe_t;

endpackage

// File: rtl/atu_ctrl.sv
module atu_ctrl
  import atu_pkg::*;
#(
  parameter int NUM_VIEWS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regWordAddr,
  input  logic [31:0] regWData,
  input  logic [31:0] fieldRdData,
  output regStrobe_t  strobe,
  output logic [31:0] regRData
);

  localparam logic [REG_IDX_W-1:0] MAX_IDX = REG_IDX_W'(NUM_VIEWS - 1);

  logic [REG_IDX_W-1:0] viewIdx;
  fieldSel_e            field;

  assign field = fieldSel_e'(regWordAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      viewIdx <= '0;
    end else if (regWr && field == FLD_VIEW) begin
      viewIdx <= (regWData[REG_IDX_W-1:0] > MAX_IDX) ? MAX_IDX
                                                     : regWData[REG_IDX_W-1:0];
    end
  end

  always_comb begin
    strobe.wrEn   = regWr && (field != FLD_VIEW);
    strobe.field  = field;
    strobe.region = viewIdx;
    strobe.data   = regWData;
  end

  assign regRData = (field == FLD_VIEW) ? {{(32-REG_IDX_W){1'b0}}, viewIdx}
                                        : fieldRdData;

  assert_index_clamp_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && field == FLD_VIEW && regWData[REG_IDX_W-1:0] > MAX_IDX)
      |=> (viewIdx == MAX_IDX));

endmodule

// File: rtl/atu_xlate.sv
module atu_xlate
  import atu_pkg::*;
#(
  parameter int NUM_OUT       = 4,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  regStrobe_t  strobe,
  input  logic [63:0] hostAddr,
  output logic [31:0] fieldRdData,
  output logic [63:0] busAddr,
  output logic [4:0]  busType,
  output logic        noMatch
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam int WIN_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  logic [31:0]      baseLo [NUM_OUT];
  logic [31:0]      baseHi [NUM_OUT];
  logic [31:0]      limit  [NUM_OUT];
  logic [31:0]      tgtLo  [NUM_OUT];
  logic [31:0]      tgtHi  [NUM_OUT];
  logic [4:0]       winType[NUM_OUT];
  logic [CNT_W-1:0] settle [NUM_OUT];
  logic [NUM_OUT-1:0] enReq;
  logic [NUM_OUT-1:0] active;
  logic [NUM_OUT-1:0] hit;

  // Register storage, one set per implemented window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReq <= '0;
      for (int i = 0; i < NUM_OUT; i++) begin
        baseLo[i]  <= '0;
        baseHi[i]  <= '0;
        limit[i]   <= '0;
        tgtLo[i]   <= '0;
        tgtHi[i]   <= '0;
        winType[i] <= '0;
        settle[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (settle[i] != '0) settle[i] <= settle[i] - 1'b1;
        if (strobe.wrEn && strobe.region == REG_IDX_W'(i)) begin
          case (strobe.field)
            FLD_CTRL1:   winType[i] <= strobe.data[4:0];
            FLD_CTRL2: begin
              if (strobe.data[ENABLE_BIT]) begin
                if (!enReq[i]) begin
                  enReq[i]  <= 1'b1;
                  settle[i] <= CNT_W'(SETTLE_CYCLES);
                end
              end else begin
                enReq[i]  <= 1'b0;
                settle[i] <= '0;
              end
            end
            FLD_BASE_LO: baseLo[i] <= strobe.data;
            FLD_BASE_HI: baseHi[i] <= strobe.data;
            FLD_LIMIT:   limit[i]  <= strobe.data;
            FLD_TGT_LO:  tgtLo[i]  <= strobe.data;
            FLD_TGT_HI:  tgtHi[i]  <= strobe.data;
            default: ;
          endcase
        end
      end
    end
  end

  // Per-window activity and range match
  for (genvar g = 0; g < NUM_OUT; g++) begin : gWin
    assign active[g] = enReq[g] && (settle[g] == '0);
    assign hit[g]    = active[g] && (hostAddr[63:32] == baseHi[g]) &&
                       (hostAddr[31:0] >= baseLo[g]) && (hostAddr[31:0] <= limit[g]);

    // Window settles before it can be seen as active
    assert_settle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && strobe.region == REG_IDX_W'(g) && strobe.field == FLD_CTRL2 &&
       strobe.data[ENABLE_BIT] && !enReq[g]) |=> !active[g]);

    assert_disable_now_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && strobe.region == REG_IDX_W'(g) && strobe.field == FLD_CTRL2 &&
       !strobe.data[ENABLE_BIT]) |=> !active[g]);

    // Writes aimed elsewhere (including unimplemented indices) leave this window alone
    assert_other_index_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrEn && strobe.region != REG_IDX_W'(g))
        |=> ($stable(tgtLo[g]) && $stable(tgtHi[g]) && $stable(baseLo[g]) &&
             $stable(baseHi[g]) && $stable(limit[g]) && $stable(winType[g])));
  end

  // Lowest-numbered hit wins
  logic [WIN_W-1:0] winIdx;
  logic             anyHit;

  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_OUT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        winIdx = WIN_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> (hit[winIdx] &&
               ((hit & ((NUM_OUT'(1) << winIdx) - NUM_OUT'(1))) == '0)));

  logic [63:0] selBase;
  logic [63:0] selTgt;

  assign selBase = {baseHi[winIdx], baseLo[winIdx]};
  assign selTgt  = {tgtHi[winIdx],  tgtLo[winIdx]};
  assign busAddr = anyHit ? (selTgt + (hostAddr - selBase)) : hostAddr;
  assign busType = anyHit ? winType[winIdx] : 5'd0;
  assign noMatch = !anyHit;

  // Readback of the window picked by the index register
  always_comb begin
    fieldRdData = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (strobe.region == REG_IDX_W'(i)) begin
        case (strobe.field)
          FLD_CTRL1:   fieldRdData = {27'd0, winType[i]};
          FLD_CTRL2:   fieldRdData = {active[i], 31'd0};
          FLD_BASE_LO: fieldRdData = baseLo[i];
          FLD_BASE_HI: fieldRdData = baseHi[i];
          FLD_LIMIT:   fieldRdData = limit[i];
          FLD_TGT_LO:  fieldRdData = tgtLo[i];
          FLD_TGT_HI:  fieldRdData = tgtHi[i];
          default:     fieldRdData = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/atu_window_unit.sv
module atu_window_unit
  import atu_pkg::*;
#(
  parameter int NUM_OUT       = 4,
  parameter int NUM_VIEWS     = 6,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regWordAddr,
  input  logic [31:0] regWData,
  output logic [31:0] regRData,
  input  logic [63:0] hostAddr,
  output logic [63:0] busAddr,
  output logic [4:0]  busType,
  output logic        noMatch
);

  regStrobe_t  strobe;
  logic [31:0] fieldRdData;

  atu_ctrl #(.NUM_VIEWS(NUM_VIEWS)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWr       (regWr),
    .regWordAddr (regWordAddr),
    .regWData    (regWData),
    .fieldRdData (fieldRdData),
    .strobe      (strobe),
    .regRData    (regRData)
  );

  atu_xlate #(.NUM_OUT(NUM_OUT), .SETTLE_CYCLES(SETTLE_CYCLES)) uXlate (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hostAddr    (hostAddr),
    .fieldRdData (fieldRdData),
    .busAddr     (busAddr),
    .busType     (busType),
    .noMatch     (noMatch)
  );

endmodule

// File: tb/tb_atu_window_unit.sv
`timescale 1ns/1ps
module tb_atu_window_unit;

  localparam logic [2:0] A_VIEW = 3'd0, A_CTRL1 = 3'd1, A_CTRL2 = 3'd2, A_BLO = 3'd3,
                         A_BHI = 3'd4, A_LIM = 3'd5, A_TLO = 3'd6, A_THI = 3'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regWordAddr = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic [63:0] hostAddr = '0;
  logic [63:0] busAddr;
  logic [4:0]  busType;
  logic        noMatch;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  atu_window_unit dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regWordAddr(regWordAddr),
    .regWData(regWData), .regRData(regRData), .hostAddr(hostAddr),
    .busAddr(busAddr), .busType(busType), .noMatch(noMatch)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regWordAddr = a; regWData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regWordAddr = a;
    #1 d = regRData;
  endtask

  task automatic lookup(input string tag, input logic [63:0] h, input logic [63:0] expAddr,
                        input logic [4:0] expType, input logic expMiss);
    @(negedge clk);
    hostAddr = h;
    #1;
    check({tag, " addr"}, busAddr, expAddr);
    check({tag, " type"}, {59'd0, busType}, {59'd0, expType});
    check({tag, " miss"}, {63'd0, noMatch}, {63'd0, expMiss});
  endtask

  task automatic programWin(input int idx, input logic [63:0] base, input logic [31:0] lim,
                            input logic [63:0] tgt, input logic [4:0] typ);
    regWrite(A_VIEW, idx);
    regWrite(A_BLO, base[31:0]);
    regWrite(A_BHI, base[63:32]);
    regWrite(A_LIM, lim);
    regWrite(A_TLO, tgt[31:0]);
    regWrite(A_THI, tgt[63:32]);
    regWrite(A_CTRL1, {27'd0, typ});
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(A_VIEW, d);  check("R1 index after reset", {32'd0, d}, 64'd0);
    for (int a = 1; a < 8; a++) begin
      regRead(3'(a), d); check("R1 register after reset", {32'd0, d}, 64'd0);
    end
    lookup("R1 lookup after reset", 64'h0, 64'h0, 5'd0, 1'b1);
  endtask

  task automatic testIndex();
    logic [31:0] d;
    regWrite(A_VIEW, 32'hFFFF_FFFF);
    regRead(A_VIEW, d); check("R2 all-ones index", {32'd0, d}, 64'd5);
    regWrite(A_VIEW, 32'd2);
    regRead(A_VIEW, d); check("R2 plain index", {32'd0, d}, 64'd2);
    regWrite(A_VIEW, 32'd9);
    regRead(A_VIEW, d); check("R2 index above range", {32'd0, d}, 64'd5);
  endtask

  task automatic testDiscovery();
    logic [31:0] d;
    int count = -1;
    for (int i = 0; i < 6; i++) begin
      regWrite(A_VIEW, i);
      regWrite(A_TLO, 32'h1234_0000);
      regRead(A_TLO, d);
      if (d != 32'h1234_0000 && count < 0) count = i;
    end
    check("R4 probe count", 64'(count), 64'd4);
    regWrite(A_VIEW, 32'd4);
    regWrite(A_CTRL2, 32'h8000_0000);
    repeat (4) @(negedge clk);
    regRead(A_CTRL2, d); check("R4 unimplemented enable", {32'd0, d}, 64'd0);
    regRead(A_TLO, d);   check("R4 unimplemented target", {32'd0, d}, 64'd0);
    // clear probe values left in implemented windows
    for (int i = 0; i < 4; i++) begin
      regWrite(A_VIEW, i);
      regWrite(A_TLO, 32'd0);
    end
  endtask

  task automatic testProgram();
    logic [31:0] d;
    programWin(1, 64'h0000_0001_8000_0000, 32'h8FFF_FFFF, 64'h0000_00AB_F000_0000, 5'd0);
    regRead(A_BLO, d);   check("R3 base low",  {32'd0, d}, 64'h8000_0000);
    regRead(A_BHI, d);   check("R3 base high", {32'd0, d}, 64'h1);
    regRead(A_LIM, d);   check("R3 limit",     {32'd0, d}, 64'h8FFF_FFFF);
    regRead(A_THI, d);   check("R3 target high", {32'd0, d}, 64'hAB);
    regWrite(A_CTRL1, 32'd5);
    regRead(A_CTRL1, d); check("R3 type field", {32'd0, d}, 64'd5);
    regWrite(A_CTRL1, 32'd0);
    // enable: write lands at the edge inside regWrite, then two more edges still settling
    regWrite(A_CTRL2, 32'h8000_0000);
    regRead(A_CTRL2, d); check("R5 settling read 1", {32'd0, d}, 64'd0);
    lookup("R5 settling lookup", 64'h1_8000_0000, 64'h1_8000_0000, 5'd0, 1'b1);
    regRead(A_CTRL2, d); check("R5 settled read", {32'd0, d}, 64'h8000_0000);
  endtask

  task automatic testTranslate();
    logic [31:0] d;
    lookup("R6 base edge",  64'h1_8000_0000, 64'hAB_F000_0000, 5'd0, 1'b0);
    lookup("R6 limit edge", 64'h1_8FFF_FFFF, 64'hAB_FFFF_FFFF, 5'd0, 1'b0);
    lookup("R9 above limit", 64'h1_9000_0000, 64'h1_9000_0000, 5'd0, 1'b1);
    lookup("R9 below base",  64'h1_7FFF_FFFF, 64'h1_7FFF_FFFF, 5'd0, 1'b1);
    lookup("R6 upper mismatch", 64'h2_8000_0000, 64'h2_8000_0000, 5'd0, 1'b1);
    programWin(0, 64'h0000_0000_1000_0000, 32'h1FFF_FFFF, 64'h0000_0003_FFFF_0000, 5'd2);
    regWrite(A_CTRL2, 32'h8000_0000);
    repeat (3) @(negedge clk);
    regRead(A_CTRL2, d); check("R5 window 0 active", {32'd0, d}, 64'h8000_0000);
    lookup("R7 carry into upper", 64'h1002_0000, 64'h4_0001_0000, 5'd2, 1'b0);
  endtask

  task automatic testPriority();
    programWin(2, 64'h0000_0001_8800_0000, 32'h8FFF_FFFF, 64'h0000_0000_5000_0000, 5'd4);
    regWrite(A_CTRL2, 32'h8000_0000);
    programWin(3, 64'h0000_0001_8800_0000, 32'h8FFF_FFFF, 64'h0000_0000_7000_0000, 5'd5);
    regWrite(A_CTRL2, 32'h8000_0000);
    repeat (4) @(negedge clk);
    lookup("R8 lowest of three", 64'h1_8800_0010, 64'hAB_F800_0010, 5'd0, 1'b0);
    regWrite(A_VIEW, 32'd1);
    regWrite(A_CTRL2, 32'd0);
    lookup("R5 R8 after disable", 64'h1_8800_0010, 64'h5000_0010, 5'd4, 1'b0);
  endtask

  task automatic testSameCycle();
    regWrite(A_VIEW, 32'd2);
    @(negedge clk);
    hostAddr = 64'h1_8800_0010;
    regWr = 1'b1; regWordAddr = A_TLO; regWData = 32'h6000_0000;
    #1 check("R10 old target before edge", busAddr, 64'h5000_0010);
    @(negedge clk);
    regWr = 1'b0;
    #1 check("R10 new target after edge", busAddr, 64'h6000_0010);
    @(negedge clk);
    regWr = 1'b1; regWordAddr = A_CTRL2; regWData = 32'd0;
    #1 check("R10 still window 2 before edge", {59'd0, busType}, 64'd4);
    @(negedge clk);
    regWr = 1'b0;
    #1 check("R10 window 3 after disable", busAddr, 64'h7000_0010);
    check("R10 window 3 type", {59'd0, busType}, 64'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIndex();
    testDiscovery();
    testProgram();
    testTranslate();
    testPriority();
    testSameCycle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule